// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station-manager side of a two-wire management bus. It runs one clause-22 style transaction at a time against an attached PHY. A request names a read or a write, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block generates the management clock itself. It drives the data line through an output and an output enable, and it observes the line on a separate input. When the frame ends, it reports completion, an error flag and, for a successful read, the 16-bit register value.

The block also checks bus ownership at three fixed points in a frame. After the preamble the line must still be high, because a low level means something is holding the bus. During a read turnaround the PHY must pull the line low. After the frame the released line must float back high. If any checkpoint fails, the frame stops at once and reports an error. This lets a missing or stuck PHY be detected with no extra hardware.

The surrounding logic issues a request with a one-cycle start pulse. It waits for the done pulse and then reads the error flag and the read value.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc and mdio_oe are low and busy, done and err are low.
- R2: Each frame begins with 32 preamble bits, each driven as 1 with mdio_oe high. Every bit is one MDC period: HALF_DIV cycles low, then HALF_DIV cycles high. The driven data only changes while mdc is low.
- R3: A read sends 14 bits, MSB first: start 01, opcode 10, PHY address, register address.
- R4: A write sends 32 bits, MSB first: start 01, opcode 01, PHY address, register address, turnaround 10, write data.
- R5: mdio_i is sampled at the end of the last preamble bit. A low level aborts the frame with err set.
- R6: After the read command, the master releases the line (mdio_oe low) for one bit. mdio_i sampled at the end of that bit must be low; if it is high, the frame aborts with err set.
- R7: A read then takes in 16 bits with the line released, MSB first, each sampled at the last cycle of the bit's high half. rdata changes only when a read completes without error.
- R8: Every frame ends with one released bit, after both reads and writes. mdio_i sampled at the end of that bit must be high, and a low level sets err.
- R9: busy is high from the edge after start until the edge that ends the last bit or the failed checkpoint. At that edge done pulses for one cycle, and err is then valid and held until the next start.
- R10: A start pulse while busy is ignored. The running frame continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| rd_nwr | input | 1 | 1 selects a read, 0 a write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wdata | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last successfully read value |
| err | output | 1 | Last frame failed a checkpoint |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line observed level |

## Verification
The bench builds the block with HALF_DIV set to 3. With that value each MDC half spans several system cycles, so the bench can confirm that the data line stays stable across a half and that every MDC edge lands where expected. A read frame still fits in under 400 cycles. That length leaves room for good reads and writes, a start pulse issued mid-frame, and a separate PHY fault for each checkpoint: a stuck-low bus, an absent PHY, and a line held low after the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_BITS  = 32;
    localparam int RCMD_BITS = 14;
    localparam int WFRM_BITS = 32;
    localparam int DATA_BITS = 16;
    localparam int CNT_W     = $clog2(PRE_BITS);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_CMD,
        PH_TA,
        PH_DATA,
        PH_END
    } phase_e;

    typedef struct packed {
        phase_e                 phase;
        logic [CNT_W:0]         cnt;
        logic [WFRM_BITS-1:0]   sh;
        logic [DATA_BITS-1:0]   rsh;
        logic                   rd;
        logic                   mdc;
        logic                   busy;
        logic                   done;
        logic                   err;
        logic [DATA_BITS-1:0]   rdata;
    } frame_state_t;
endpackage

// File: rtl/mdio_halftick.sv
module mdio_halftick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (HALF_DIV > 1) begin : g_spacing
            p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("tick pulses too close");
        end
    endgenerate
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        start,
    input  logic        rd_nwr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    input  logic        mdio_i,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);
    frame_state_t q, d;

    always_comb begin
        logic bit_end;
        logic fail;
        logic fin;
        d       = q;
        d.done  = 1'b0;
        fail    = 1'b0;
        fin     = 1'b0;
        bit_end = 1'b0;
        if (q.phase == PH_IDLE) begin
            if (start) begin
                d.phase = PH_PRE;
                d.cnt   = (CNT_W+1)'(PRE_BITS - 1);
                d.rd    = rd_nwr;
                d.busy  = 1'b1;
                d.mdc   = 1'b0;
                d.err   = 1'b0;
                if (rd_nwr) d.sh = {2'b01, 2'b10, phy_addr, reg_addr, 18'd0};
                else        d.sh = {2'b01, 2'b01, phy_addr, reg_addr, 2'b10, wdata};
            end
        end else if (tick) begin
            if (!q.mdc) d.mdc = 1'b1;
            else begin
                d.mdc   = 1'b0;
                bit_end = 1'b1;
            end
        end

        if (bit_end) begin
            case (q.phase)
                PH_PRE: begin
                    if (q.cnt == '0) begin
                        if (!mdio_i) fail = 1'b1;
                        else begin
                            d.phase = PH_CMD;
                            d.cnt   = q.rd ? (CNT_W+1)'(RCMD_BITS - 1)
                                           : (CNT_W+1)'(WFRM_BITS - 1);
                        end
                    end else d.cnt = q.cnt - 1'b1;
                end
                PH_CMD: begin
                    d.sh = {q.sh[WFRM_BITS-2:0], 1'b0};
                    if (q.cnt == '0) d.phase = q.rd ? PH_TA : PH_END;
                    else             d.cnt   = q.cnt - 1'b1;
                end
                PH_TA: begin
                    if (mdio_i) fail = 1'b1;
                    else begin
                        d.phase = PH_DATA;
                        d.cnt   = (CNT_W+1)'(DATA_BITS - 1);
                    end
                end
                PH_DATA: begin
                    d.rsh = {q.rsh[DATA_BITS-2:0], mdio_i};
                    if (q.cnt == '0) d.phase = PH_END;
                    else             d.cnt   = q.cnt - 1'b1;
                end
                PH_END: begin
                    if (!mdio_i) fail = 1'b1;
                    else         fin  = 1'b1;
                end
                default: ;
            endcase
        end

        if (fail || fin) begin
            d.phase = PH_IDLE;
            d.busy  = 1'b0;
            d.done  = 1'b1;
            d.mdc   = 1'b0;
            d.err   = fail;
            if (fin && q.rd) d.rdata = q.rsh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign err     = q.err;
    assign rdata   = q.rdata;
    assign mdc     = q.mdc;
    assign mdio_oe = (q.phase == PH_PRE) || (q.phase == PH_CMD);
    assign mdio_o  = (q.phase == PH_PRE) ? 1'b1 :
                     (q.phase == PH_CMD) ? q.sh[WFRM_BITS-1] : 1'b0;

    p_data_moves_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && !$stable(mdio_o)) |-> !mdc)
        else $error("driven data changed while mdc high");

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe))
        else $error("bus active while idle");

    p_preamble_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_PRE && q.cnt == '0 && q.mdc && tick && !mdio_i) |=> (done && err))
        else $error("low after preamble not flagged");

    p_turnaround_check_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_TA && q.mdc && tick && mdio_i) |=> (done && err))
        else $error("missing turnaround low not flagged");

    p_rdata_only_on_success_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> (done && !err))
        else $error("rdata changed without good read");

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done))
        else $error("done not a single idle pulse");
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd_nwr,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        err,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic tick;

    mdio_halftick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    mdio_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start),
        .rd_nwr   (rd_nwr),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wdata    (wdata),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .rdata    (rdata),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );
endmodule

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int H = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wdata = '0;
    logic        mdio_i = 1'b1;
    logic        busy, done, err, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;

    int errors = 0;
    int checks = 0;
    logic [15:0] exp_rdata = 16'h0000;

    logic [0:79] ex_oe, ex_o, in_v;
    int nbits;
    int abort_at;

    always #2.5 clk = ~clk;

    mdio_master #(.HALF_DIV(H)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wdata(wdata),
        .busy(busy), .done(done), .rdata(rdata), .err(err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string region(input bit rd, input int b);
        if (b < 32) return "R2";
        if (rd) begin
            if (b < 46) return "R3";
            if (b == 46) return "R6";
            if (b < 63) return "R7";
            return "R8";
        end
        if (b < 64) return "R4";
        return "R8";
    endfunction

    // mode: 0 healthy PHY, 1 bus stuck low, 2 no PHY (floats high), 3 held low after frame
    task automatic build(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] rv, input int mode);
        logic [13:0] rc;
        logic [31:0] wf;
        int b = 0;
        for (int i = 0; i < 32; i++) begin
            ex_oe[b] = 1'b1; ex_o[b] = 1'b1; in_v[b] = (mode == 1) ? 1'b0 : 1'b1; b++;
        end
        if (rd) begin
            rc = {2'b01, 2'b10, pa, ra};
            for (int i = 0; i < 14; i++) begin
                ex_oe[b] = 1'b1; ex_o[b] = rc[13-i]; in_v[b] = (mode == 1) ? 1'b0 : 1'b1; b++;
            end
            ex_oe[b] = 1'b0; ex_o[b] = 1'b0; in_v[b] = (mode == 2) ? 1'b1 : 1'b0; b++;
            for (int i = 0; i < 16; i++) begin
                ex_oe[b] = 1'b0; ex_o[b] = 1'b0;
                in_v[b] = (mode == 1) ? 1'b0 : (mode == 2) ? 1'b1 : rv[15-i]; b++;
            end
        end else begin
            wf = {2'b01, 2'b01, pa, ra, 2'b10, wd};
            for (int i = 0; i < 32; i++) begin
                ex_oe[b] = 1'b1; ex_o[b] = wf[31-i]; in_v[b] = (mode == 1) ? 1'b0 : 1'b1; b++;
            end
        end
        ex_oe[b] = 1'b0; ex_o[b] = 1'b0; in_v[b] = (mode == 1 || mode == 3) ? 1'b0 : 1'b1; b++;
        nbits = b;
        if (mode == 1)             abort_at = 31;
        else if (mode == 2 && rd)  abort_at = 46;
        else if (mode == 3)        abort_at = b - 1;
        else                       abort_at = -1;
    endtask

    task automatic run(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                       input logic [15:0] wd, input logic [15:0] rv, input int mode,
                       input bit inject, input string end_req);
        int total;
        bit exp_err;
        build(rd, pa, ra, wd, rv, mode);
        exp_err = (abort_at >= 0);
        total = exp_err ? (abort_at + 1) : nbits;
        @(negedge clk);
        start = 1'b1; rd_nwr = rd; phy_addr = pa; reg_addr = ra; wdata = wd;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < total * 2 * H; j++) begin
            int b;
            bit hi;
            b  = j / (2 * H);
            hi = (j % (2 * H)) >= H;
            mdio_i = in_v[b];
            if (inject && j == 10) begin
                start = 1'b1; rd_nwr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
            end
            if (inject && j == 11) start = 1'b0;
            chk(mdc == hi, "R2", "mdc phase", mdc, hi);
            chk(mdio_oe == ex_oe[b], inject ? "R10" : region(rd, b), "oe", mdio_oe, ex_oe[b]);
            if (ex_oe[b])
                chk(mdio_o == ex_o[b], inject ? "R10" : region(rd, b), "mdio_o", mdio_o, ex_o[b]);
            chk(busy && !done, "R9", "busy during frame", {busy, done}, 2'b10);
            @(negedge clk);
        end
        if (rd && !exp_err) exp_rdata = rv;
        chk(!busy && done, "R9", "done pulse", {busy, done}, 2'b01);
        chk(err == exp_err, end_req, "err", err, exp_err);
        chk(rdata == exp_rdata, "R7", "rdata", rdata, exp_rdata);
        mdio_i = 1'b1;
        @(negedge clk);
        chk(!done && err == exp_err, "R9", "done single, err held", {done, err}, {1'b0, exp_err});
        chk(!mdc && !mdio_oe, "R1", "idle bus", {mdc, mdio_oe}, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mdc && !mdio_oe && !busy && !done && !err, "R1", "reset state",
            {mdc, mdio_oe, busy, done, err}, 0);
        run(1'b1, 5'h05, 5'h01, 16'h0000, 16'hA5C3, 0, 1'b0, "R7");
        run(1'b0, 5'h1F, 5'h1E, 16'h8001, 16'h0000, 0, 1'b1, "R4");
        run(1'b1, 5'h03, 5'h02, 16'h0000, 16'h1234, 1, 1'b0, "R5");
        run(1'b1, 5'h07, 5'h04, 16'h0000, 16'hFFFF, 2, 1'b0, "R6");
        run(1'b1, 5'h0A, 5'h11, 16'h0000, 16'h5A5A, 3, 1'b0, "R8");
        run(1'b0, 5'h02, 5'h00, 16'h7E81, 16'h0000, 3, 1'b0, "R8");
        run(1'b0, 5'h11, 5'h09, 16'hC3C3, 16'h0000, 1, 1'b0, "R5");
        run(1'b1, 5'h00, 5'h00, 16'h0000, 16'h0001, 0, 1'b0, "R3");
        run(1'b0, 5'h15, 5'h0A, 16'hFFFE, 16'h0000, 2, 1'b0, "R8");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule